// File: doc/BRIEF.md
# Quad ADC Capture Sequencer

This block runs a four-channel sampling ADC whose parallel outputs sit on two shared 14-bit tri-state buses: one bus carries channels A and B, the other carries C and D, and every channel has its own active-low output enable. From a fast system clock the block produces the common start-convert strobe with a programmable period and near-equal high and low phases. Within each conversion period it pulses the enables one channel at a time per bus and samples each bus once its driver has settled.

The converter returns the result of a conversion three strobes after that conversion's start. The block therefore throws away the words that arrive during the first three periods of a run and labels every later word with the index of the conversion that produced it. Each channel leaves the block as its own stream of valid pulse, two's-complement data and out-of-range flag. The period and dead time are forced into safe ranges before use. While reset is active or the block is not enabled, the strobe stays low and every enable stays high.

Top module: `quad_adc_sequencer`

## Requirements
- R1: While `rst` is high or `enable` is low, `startConv` is 0, `enN` is 4'hF and `outValid` is 0. Dropping `enable` during a run returns all three to this idle state at the next clock edge.
- R2: After `enable` is seen high, `startConv` first rises two clock edges later. The programmed period `periodCfg` is used clamped to [MIN_PERIOD, MAX_PERIOD] clock cycles, and it is latched at run start and at each period boundary.
- R3: In each period of P cycles, `startConv` is high for floor(P/2) cycles and low for the remaining P - floor(P/2) cycles.
- R4: Counting from the first high cycle of `startConv` as cycle 0, enable bits 0 (A) and 2 (C) are low in cycles SETTLE to SETTLE+SAMPLE_WAIT-1. Enable bits 1 (B) and 3 (D) are low for SAMPLE_WAIT cycles starting D cycles after the first window closes, where D is `deadCfg` clamped to [1, MIN_PERIOD-1-SETTLE-2*SAMPLE_WAIT].
- R5: The two enables of one bus (bits 0/1, bits 2/3) are never low in the same cycle, and all enables are high in the cycle in which `startConv` rises.
- R6: Each bus is sampled in the last low cycle of an enable window. The matching `outValid` bit is high for exactly one cycle, the cycle after that window.
- R7: Bus bit 14 is the out-of-range flag, passed to `outOvf`. Bits 13:0 are offset binary with bit 13 as MSB, and `outData` is these bits with bit 13 inverted (two's complement, so 14'h2000 becomes 0).
- R8: The words captured in the first three periods of a run produce no `outValid`. The word captured in period k (k ≥ 3) carries sample index k-3 on `outSample`, and the index restarts from 0 in each run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control; low keeps the block idle |
| periodCfg | input | PER_W | Requested conversion period in clock cycles |
| deadCfg | input | DEAD_W | Requested gap in cycles between enable windows |
| busAB | input | DATA_W+1 | Shared bus of channels A/B: {flag, data} |
| busCD | input | DATA_W+1 | Shared bus of channels C/D: {flag, data} |
| startConv | output | 1 | Start-convert strobe to the converter |
| enN | output | 4 | Active-low output enables, bit order A, B, C, D |
| outValid | output | 4 | Per-channel word strobe |
| outData | output | 4*DATA_W | Per-channel two's-complement data, channel n at [n*DATA_W +: DATA_W] |
| outOvf | output | 4 | Per-channel out-of-range flag |
| outSample | output | 4*SAMP_W | Per-channel sample index, channel n at [n*SAMP_W +: SAMP_W] |

## Verification
The hardest case to reach is the pairing of a captured word with the conversion that produced it. The bus holds each result only while its enable is low and only after a settle delay, and the result is three periods old. The bench models the converter as a register per channel that takes conversion k-3's word shortly after rise k. It drives a junk pattern on a bus whenever the bus is undriven, contended or still settling, so a capture taken one cycle early or from the wrong period shows up as a wrong value. Runs are stopped during priming and restarted with odd, minimum, below-minimum and above-maximum periods and dead times, which exercises the clamps and the restart of the sample index.

// File: rtl/qadc_pkg.sv
package qadc_pkg;
  localparam int NUM_CH = 4;
  localparam int NUM_BUS = 2;

  typedef struct packed {
    logic capFirst;
    logic capSecond;
    logic primed;
    logic restart;
  } qadc_strobe_t;
endpackage

// File: rtl/qadc_ctrl.sv
module qadc_ctrl
  import qadc_pkg::*;
#(
  parameter int PER_W       = 18,
  parameter int MIN_PERIOD  = 20,
  parameter int MAX_PERIOD  = 200000,
  parameter int DEAD_W      = 4,
  parameter int SETTLE      = 6,
  parameter int SAMPLE_WAIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [PER_W-1:0]  periodCfg,
  input  logic [DEAD_W-1:0] deadCfg,
  output logic              startConv,
  output logic [3:0]        enN,
  output qadc_strobe_t      strobe
);
  localparam int DEAD_MAX = MIN_PERIOD - 1 - SETTLE - 2 * SAMPLE_WAIT;
  localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_PERIOD);
  localparam logic [PER_W-1:0] MAX_P = PER_W'(MAX_PERIOD);
  localparam logic [DEAD_W-1:0] D_MAX = DEAD_W'(DEAD_MAX);
  localparam logic [PER_W-1:0] FIRST_ON = PER_W'(SETTLE);
  localparam logic [PER_W-1:0] FIRST_CAP = PER_W'(SETTLE + SAMPLE_WAIT);
  localparam logic [PER_W-1:0] WAIT_P = PER_W'(SAMPLE_WAIT);

  logic              active;
  logic [PER_W-1:0]  cnt;
  logic [PER_W-1:0]  perQ;
  logic [DEAD_W-1:0] deadQ;
  logic [1:0]        primeCnt;

  logic [PER_W-1:0]  perClamp;
  logic [DEAD_W-1:0] deadClamp;
  logic [PER_W-1:0]  halfQ;
  logic [PER_W-1:0]  secStart;
  logic              run;
  logic              lastCnt;
  logic              firstLo;
  logic              secondLo;
  logic              startD;
  logic [3:0]        enD;

  always_comb begin
    if (periodCfg < MIN_P)      perClamp = MIN_P;
    else if (periodCfg > MAX_P) perClamp = MAX_P;
    else                        perClamp = periodCfg;
    if (deadCfg == '0)          deadClamp = DEAD_W'(1);
    else if (deadCfg > D_MAX)   deadClamp = D_MAX;
    else                        deadClamp = deadCfg;
  end

  always_comb begin
    run      = active && enable;
    halfQ    = perQ >> 1;
    lastCnt  = (cnt == perQ - PER_W'(1));
    secStart = FIRST_CAP + PER_W'(deadQ);
    firstLo  = (cnt >= FIRST_ON) && (cnt < FIRST_CAP);
    secondLo = (cnt >= secStart) && (cnt < secStart + WAIT_P);
    startD   = run && (cnt < halfQ);
    enD      = run ? ~{secondLo, firstLo, secondLo, firstLo} : 4'hF;
    strobe.capFirst  = run && (cnt == FIRST_CAP);
    strobe.capSecond = run && (cnt == secStart + WAIT_P);
    strobe.primed    = (primeCnt == 2'd3);
    strobe.restart   = !run;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      active    <= 1'b0;
      cnt       <= '0;
      perQ      <= MIN_P;
      deadQ     <= DEAD_W'(1);
      primeCnt  <= '0;
      startConv <= 1'b0;
      enN       <= 4'hF;
    end else if (!active) begin
      active    <= 1'b1;
      cnt       <= '0;
      perQ      <= perClamp;
      deadQ     <= deadClamp;
      primeCnt  <= '0;
      startConv <= 1'b0;
      enN       <= 4'hF;
    end else begin
      startConv <= startD;
      enN       <= enD;
      if (lastCnt) begin
        cnt   <= '0;
        perQ  <= perClamp;
        deadQ <= deadClamp;
        if (primeCnt != 2'd3) primeCnt <= primeCnt + 2'd1;
      end else begin
        cnt <= cnt + PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/qadc_dpath.sv
module qadc_dpath
  import qadc_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int SAMP_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  qadc_strobe_t               strobe,
  input  logic [DATA_W:0]            busAB,
  input  logic [DATA_W:0]            busCD,
  output logic [NUM_CH-1:0]          outValid,
  output logic [NUM_CH*DATA_W-1:0]   outData,
  output logic [NUM_CH-1:0]          outOvf,
  output logic [NUM_CH*SAMP_W-1:0]   outSample
);
  logic [SAMP_W-1:0] sampIdx;
  logic [DATA_W:0]   busArr [NUM_BUS];

  assign busArr[0] = busAB;
  assign busArr[1] = busCD;

  always_ff @(posedge clk) begin
    if (rst || strobe.restart)               sampIdx <= '0;
    else if (strobe.capSecond && strobe.primed) sampIdx <= sampIdx + SAMP_W'(1);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int BUS = ch / 2;
    logic              slotCap;
    logic              validQ;
    logic              ovfQ;
    logic [DATA_W-1:0] dataQ;
    logic [SAMP_W-1:0] sampQ;

    if (ch % 2 == 0) begin : g_first
      assign slotCap = strobe.capFirst;
    end else begin : g_second
      assign slotCap = strobe.capSecond;
    end

    always_ff @(posedge clk) begin
      if (rst || strobe.restart) validQ <= 1'b0;
      else                       validQ <= slotCap && strobe.primed;
      if (slotCap && strobe.primed) begin
        dataQ <= {~busArr[BUS][DATA_W-1], busArr[BUS][DATA_W-2:0]};
        ovfQ  <= busArr[BUS][DATA_W];
        sampQ <= sampIdx;
      end
    end

    assign outValid[ch]                     = validQ;
    assign outOvf[ch]                       = ovfQ;
    assign outData[ch*DATA_W +: DATA_W]     = dataQ;
    assign outSample[ch*SAMP_W +: SAMP_W]   = sampQ;
  end
endmodule

// File: rtl/quad_adc_sequencer.sv
module quad_adc_sequencer
  import qadc_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int PER_W       = 18,
  parameter int MIN_PERIOD  = 20,
  parameter int MAX_PERIOD  = 200000,
  parameter int DEAD_W      = 4,
  parameter int SETTLE      = 6,
  parameter int SAMPLE_WAIT = 4,
  parameter int SAMP_W      = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enable,
  input  logic [PER_W-1:0]          periodCfg,
  input  logic [DEAD_W-1:0]         deadCfg,
  input  logic [DATA_W:0]           busAB,
  input  logic [DATA_W:0]           busCD,
  output logic                      startConv,
  output logic [3:0]                enN,
  output logic [3:0]                outValid,
  output logic [4*DATA_W-1:0]       outData,
  output logic [3:0]                outOvf,
  output logic [4*SAMP_W-1:0]       outSample
);
  qadc_strobe_t strobe;

  qadc_ctrl #(
    .PER_W(PER_W), .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD),
    .DEAD_W(DEAD_W), .SETTLE(SETTLE), .SAMPLE_WAIT(SAMPLE_WAIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable),
    .periodCfg(periodCfg), .deadCfg(deadCfg),
    .startConv(startConv), .enN(enN), .strobe(strobe)
  );

  qadc_dpath #(.DATA_W(DATA_W), .SAMP_W(SAMP_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .busAB(busAB), .busCD(busCD),
    .outValid(outValid), .outData(outData),
    .outOvf(outOvf), .outSample(outSample)
  );
endmodule

// File: rtl/qadc_checker.sv
module qadc_checker #(
  parameter int MIN_PERIOD = 20
) (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       startConv,
  input logic [3:0] enN,
  input logic [3:0] outValid
);
  int unsigned hiLen;

  always_ff @(posedge clk) begin
    if (rst)            hiLen <= 0;
    else if (startConv) hiLen <= hiLen + 1;
    else                hiLen <= 0;
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!startConv && enN == 4'hF && outValid == 4'h0));

  p_bus_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!enN[0] && !enN[1]) && !(!enN[2] && !enN[3]));

  p_rise_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(startConv) |-> enN == 4'hF);

  p_high_min_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(startConv) && $past(enable)) |-> hiLen >= MIN_PERIOD / 2);

  p_capture_window_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid[0] |-> $past(enN[0]) == 1'b0) and (outValid[3] |-> $past(enN[3]) == 1'b0));

  p_slot_pair_r4: assert property (@(posedge clk) disable iff (rst)
    outValid[0] == outValid[2] && outValid[1] == outValid[3]);
endmodule

bind quad_adc_sequencer qadc_checker #(.MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk(clk), .rst(rst), .enable(enable),
  .startConv(startConv), .enN(enN), .outValid(outValid)
);

// File: tb/sim_quad_adc_sequencer.sv
`timescale 1ns/1ps
module sim_quad_adc_sequencer;
  localparam int DW = 14, PW = 18, SWD = 16;
  localparam int MINP = 20, MAXP = 60, SET = 6, WT = 4;
  localparam int DMAX = MINP - 1 - SET - 2 * WT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [PW-1:0] periodCfg = '0;
  logic [3:0] deadCfg = '0;
  logic [DW:0] busAB = '0, busCD = '0;
  logic startConv;
  logic [3:0] enN, outValid, outOvf;
  logic [4*DW-1:0] outData;
  logic [4*SWD-1:0] outSample;

  always #2.5 clk = ~clk;

  quad_adc_sequencer #(.MAX_PERIOD(MAXP)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .periodCfg(periodCfg), .deadCfg(deadCfg),
    .busAB(busAB), .busCD(busCD), .startConv(startConv), .enN(enN),
    .outValid(outValid), .outData(outData), .outOvf(outOvf), .outSample(outSample));

  int compared = 0, mismatched = 0;
  bit done = 0;
  bit running = 0;
  int ph, k, P, H, D;
  int lowCnt [4];
  logic [DW:0] adcReg [4];

  function automatic logic [DW:0] word(int ch, int n);
    case (n % 5)
      0: return {1'b1, 14'h3FFF};
      1: return {1'b1, 14'h0000};
      2: return {1'b0, 14'h2000};
      3: return {1'b0, 14'h1FFF};
      default: return {1'b0, 14'(n * 1237 + ch * 4099 + 17)};
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkCycle();
    logic [3:0] expEn, expV;
    bit expSc;
    if (running) begin
      expSc = (ph < H);
      expEn = 4'hF;
      if (ph >= SET && ph < SET + WT) begin expEn[0] = 1'b0; expEn[2] = 1'b0; end
      if (ph >= SET + WT + D && ph < SET + 2 * WT + D) begin expEn[1] = 1'b0; expEn[3] = 1'b0; end
      if (ph == 0) chk(startConv == 1'b1, "R2", "rise", startConv, 1);
      else chk(startConv == expSc, "R3", "startConv phase", startConv, expSc);
      chk(enN == expEn, "R4", "enable schedule", enN, expEn);
      expV = 4'h0;
      if (k >= 3 && ph == SET + WT) expV = 4'b0101;
      if (k >= 3 && ph == SET + 2 * WT + D) expV = 4'b1010;
      chk(outValid == expV, (k < 3) ? "R8" : "R6", "outValid", outValid, expV);
      for (int ch = 0; ch < 4; ch++) begin
        if (expV[ch] && outValid[ch]) begin
          logic [DW:0] w;
          logic [DW-1:0] ed;
          w = word(ch, k - 3);
          ed = {~w[DW-1], w[DW-2:0]};
          chk(outData[ch*DW +: DW] == ed, "R7", "data", outData[ch*DW +: DW], ed);
          chk(outOvf[ch] == w[DW], "R7", "overflow", outOvf[ch], w[DW]);
          chk(outSample[ch*SWD +: SWD] == SWD'(k - 3), "R8", "sample index",
              outSample[ch*SWD +: SWD], k - 3);
        end
      end
      if (ph == 3)
        for (int ch = 0; ch < 4; ch++)
          adcReg[ch] = (k >= 3) ? word(ch, k - 3) : (15'h1234 ^ 15'(ch));
      ph++;
      if (ph == P) begin ph = 0; k++; end
    end else begin
      chk(startConv == 1'b0 && enN == 4'hF && outValid == 4'h0, "R1", "idle outputs",
          {startConv, enN, outValid}, 9'h0F0);
    end
    for (int ch = 0; ch < 4; ch++) lowCnt[ch] = enN[ch] ? 0 : lowCnt[ch] + 1;
  endtask

  task automatic driveBus();
    logic [DW:0] v [2];
    for (int b = 0; b < 2; b++) begin
      int c0;
      c0 = 2 * b;
      if (!enN[c0] && !enN[c0+1]) v[b] = 15'h5555;
      else if (!enN[c0] && lowCnt[c0] >= 2) v[b] = adcReg[c0];
      else if (!enN[c0+1] && lowCnt[c0+1] >= 2) v[b] = adcReg[c0+1];
      else v[b] = 15'h2AAA;
    end
    busAB = v[0];
    busCD = v[1];
  endtask

  task automatic cycle();
    @(negedge clk);
    checkCycle();
    driveBus();
  endtask

  task automatic runFor(int pcfg, int dcfg, int periods);
    periodCfg = PW'(pcfg);
    deadCfg = 4'(dcfg);
    P = (pcfg < MINP) ? MINP : (pcfg > MAXP) ? MAXP : pcfg;
    H = P / 2;
    D = (dcfg < 1) ? 1 : (dcfg > DMAX) ? DMAX : dcfg;
    enable = 1'b1;
    cycle();
    running = 1; ph = 0; k = 0;
    repeat (periods * P) cycle();
    enable = 1'b0;
    running = 0;
    repeat (3) cycle();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int ch = 0; ch < 4; ch++) begin lowCnt[ch] = 0; adcReg[ch] = '0; end
    repeat (3) cycle();          // R1: reset state
    enable = 1'b1;               // R1: reset dominates enable
    repeat (3) cycle();
    enable = 1'b0;
    cycle();
    rst = 1'b0;
    repeat (4) cycle();          // R1: idle while not enabled
    runFor(20, 1, 12);           // minimum period, minimum dead time
    runFor(5, 0, 8);             // R2 clamp to minimum, R4 dead-time floor
    runFor(33, 3, 10);           // R3 odd period split
    runFor(1000, 15, 7);         // R2 clamp to maximum, R4 dead-time ceiling
    runFor(24, 2, 2);            // R8 stopped during priming
    runFor(24, 2, 5);            // R8 index restarts at 0
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule